// File: doc/BRIEF.md
# Asynchronous Message Capture Buffer

This block catches one variable-length status message from an internal 32-bit word stream and holds it so software can read it. Typical messages are transmit underflow or sequence-error reports. The stream carries a valid strobe and an end-of-packet marker. It has no back-pressure, so any word the buffer does not take is lost.

Software drives the buffer through a two-bit control write. Bit 0 clears the buffer and bit 1 arms it. The normal sequence is to clear, poll the idle flag in the status word, and then arm. Once armed, the buffer waits for the first word of a message and stores words until the end-of-packet marker arrives. It then reports done together with the word count and raises its interrupt line. A message longer than the storage is cut off and reported as an error. Capture is one-shot: after done or error the buffer ignores the stream until software clears it and arms it again. Captured words are read through a byte-addressed window: word i sits at byte address 4*i, and its data appears one cycle after the address.

Top module: `msg_capture_buf`

## Requirements
- R1: After reset the status word reads idle=1 (bit 2), error=0 (bit 1), done=0 (bit 0), count=0 (bits 31:16), and irq_o is low.
- R2: A control write with bit 1 set and bit 0 clear arms the buffer only when it is idle. The idle bit reads 0 from the next cycle. In the done or error state the same write changes nothing.
- R3: A control write with bit 0 set returns the buffer from any state to idle with count 0 and irq_o low on the next cycle. This holds even when bit 1 is set in the same write.
- R4: An armed buffer starts storing only at the first word of a message. Words of a message already in progress when the buffer was armed are skipped, and the count stays 0.
- R5: Each stored word increments the count by one. The word carrying the end-of-packet marker is stored, and then the done bit (bit 0) sets.
- R6: When a message holds more than DEPTH words, the first DEPTH words are kept. The next word sets the error bit (bit 1), and the count stays at DEPTH.
- R7: While done or error is set, stream words change neither the count nor the stored words.
- R8: Reading byte address 4*i returns captured word i on rd_data_o one cycle after the address is presented.
- R9: irq_o is high exactly while done or error is set.
- R10: Stream words that arrive while the buffer is idle are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Stream word strobe |
| msg_data_i | input | DATA_W | Stream word |
| msg_last_i | input | 1 | End-of-packet marker on this word |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 2 | Bit 0 clear, bit 1 arm |
| status_o | output | 32 | {count[15:0], 13'b0, idle, error, done} |
| rd_addr_i | input | IDX_W+2 | Byte address into the captured words |
| rd_data_o | output | DATA_W | Read data, one cycle after the address |
| irq_o | output | 1 | High while a message is done or in error |

## Verification
A stream word or a control write that is sampled at a rising edge changes status_o and irq_o right after that edge. The bench therefore drives its inputs on the falling edge and compares both outputs with a behavioural model on the next falling edge. Read data goes through one register, so each window read presents the address, waits one full cycle, and samples rd_data_o on the following falling edge. Scenarios cover the following cases, each checked against its exact expected count:
- a word arriving while idle
- arming in the middle of a message
- single-word messages
- messages of exactly DEPTH words
- oversized messages
- gaps in the valid strobe
- arm and clear writes given in each state

// File: rtl/msg_cap_pkg.sv
package msg_cap_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARMED = 3'd1,
    S_CAPT  = 3'd2,
    S_DONE  = 3'd3,
    S_ERR   = 3'd4
  } cap_state_e;

  localparam int unsigned ST_DONE_BIT = 0;
  localparam int unsigned ST_ERR_BIT  = 1;
  localparam int unsigned ST_IDLE_BIT = 2;
  localparam int unsigned ST_CNT_LSB  = 16;
  localparam int unsigned ST_CNT_W    = 16;
endpackage

// File: rtl/msg_frame_tracker.sv
// Follows message boundaries on the stream, whether or not the buffer is armed.
module msg_frame_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic last_i,
  output logic msg_start_o
);
  logic in_msg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_msg_q <= 1'b0;
    else if (valid_i) in_msg_q <= !last_i;
  end

  assign msg_start_o = !in_msg_q;

  p_boundary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> msg_start_o);
endmodule

// File: rtl/msg_word_store.sv
module msg_word_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[rd_idx_i];
  end

  assign rd_data_o = rd_q;

  p_wr_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (32'(wr_idx_i) < DEPTH));
endmodule

// File: rtl/msg_cap_fsm.sv
module msg_cap_fsm
  import msg_cap_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             word_i,
  input  logic             last_i,
  input  logic             msg_start_i,
  output cap_state_e       state_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  cap_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_en_o = 1'b0;
    if (clear_i) begin
      state_d = S_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (start_i) state_d = S_ARMED;
        S_ARMED: if (word_i && msg_start_i) begin
          wr_en_o = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          state_d = last_i ? S_DONE : S_CAPT;
        end
        S_CAPT: if (word_i) begin
          if (full) begin
            state_d = S_ERR;
          end else begin
            wr_en_o = 1'b1;
            cnt_d   = cnt_q + 1'b1;
            if (last_i) state_d = S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o  = state_q;
  assign count_o  = cnt_q;
  assign wr_idx_o = cnt_q[IDX_W-1:0];

  p_clear_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_q == S_IDLE) && (cnt_q == '0));
  p_start_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i && state_q == S_IDLE) |=> (state_q == S_ARMED));
  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_DONE || state_q == S_ERR) && !clear_i) |=> $stable(state_q) && $stable(cnt_q));
  p_err_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ERR) |-> (cnt_q == CNT_W'(DEPTH)));
  p_idle_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !wr_en_o);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/msg_capture_buf.sv
module msg_capture_buf
  import msg_cap_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned AW    = IDX_W + 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [DATA_W-1:0] msg_data_i,
  input  logic              msg_last_i,
  input  logic              ctrl_we_i,
  input  logic [1:0]        ctrl_wdata_i,
  output logic [31:0]       status_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  cap_state_e       state;
  logic [CNT_W-1:0] count;
  logic             msg_start, wr_en, clear, start;
  logic [IDX_W-1:0] wr_idx;
  logic             unused_addr_lo;

  assign clear = ctrl_we_i && ctrl_wdata_i[0];
  assign start = ctrl_we_i && ctrl_wdata_i[1];
  assign unused_addr_lo = ^rd_addr_i[1:0];

  msg_frame_tracker i_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (msg_valid_i),
    .last_i      (msg_last_i),
    .msg_start_o (msg_start)
  );

  msg_cap_fsm #(.DEPTH(DEPTH)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .start_i     (start),
    .word_i      (msg_valid_i),
    .last_i      (msg_last_i),
    .msg_start_i (msg_start),
    .state_o     (state),
    .count_o     (count),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx)
  );

  msg_word_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (msg_data_i),
    .rd_idx_i  (rd_addr_i[AW-1:2]),
    .rd_data_o (rd_data_o)
  );

  always_comb begin
    status_o = '0;
    status_o[ST_DONE_BIT] = (state == S_DONE);
    status_o[ST_ERR_BIT]  = (state == S_ERR);
    status_o[ST_IDLE_BIT] = (state == S_IDLE);
    status_o[ST_CNT_LSB +: ST_CNT_W] = ST_CNT_W'(count);
  end

  assign irq_o = (state == S_DONE) || (state == S_ERR);

  p_irq_after_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(msg_valid_i));
  p_irq_drop_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clear));
  p_flags_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[2:0]));
endmodule

// File: tb/test_msg_capture_buf.sv
module test_msg_capture_buf;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH) + 2;
  localparam int M_IDLE = 0, M_ARMED = 1, M_CAPT = 2, M_DONE = 3, M_ERR = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic msg_valid_i = 1'b0;
  logic [31:0] msg_data_i = '0;
  logic msg_last_i = 1'b0;
  logic ctrl_we_i = 1'b0;
  logic [1:0] ctrl_wdata_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [31:0] status_o, rd_data_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  int m_st;
  bit m_in;
  logic [31:0] m_q[$];

  always #4 clk_i = ~clk_i;

  msg_capture_buf #(.DEPTH(DEPTH), .DATA_W(32)) i_msg_capture_buf (
    .clk_i, .rst_ni, .msg_valid_i, .msg_data_i, .msg_last_i,
    .ctrl_we_i, .ctrl_wdata_i, .status_o, .rd_addr_i, .rd_data_o, .irq_o
  );

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = M_IDLE; m_in = 1'b0; m_q.delete();
    end else begin
      if (ctrl_we_i && ctrl_wdata_i[0]) begin
        m_st = M_IDLE; m_q.delete();
      end else if (m_st == M_IDLE) begin
        if (ctrl_we_i && ctrl_wdata_i[1]) m_st = M_ARMED;
      end else if (msg_valid_i) begin
        if (m_st == M_ARMED && !m_in) begin
          m_q.push_back(msg_data_i);
          m_st = msg_last_i ? M_DONE : M_CAPT;
        end else if (m_st == M_CAPT) begin
          if (m_q.size() < DEPTH) begin
            m_q.push_back(msg_data_i);
            if (msg_last_i) m_st = M_DONE;
          end else m_st = M_ERR;
        end
      end
      if (msg_valid_i) m_in = !msg_last_i;
    end
  end

  function automatic logic [31:0] m_status();
    return {16'(m_q.size()), 13'b0, m_st == M_IDLE, m_st == M_ERR, m_st == M_DONE};
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R1 R2 R3 R4 R5 R6 R7 R9 R10)
  always @(negedge clk_i) begin
    if (running) begin
      check32("R5/R6 status per cycle", status_o, m_status());
      check32("R9 irq per cycle", {31'b0, irq_o}, {31'b0, m_st == M_DONE || m_st == M_ERR});
    end
  end

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic send(logic [31:0] d, bit last);
    msg_valid_i = 1'b1; msg_data_i = d; msg_last_i = last;
    tick();
    msg_valid_i = 1'b0; msg_last_i = 1'b0;
  endtask

  task automatic send_msg(int n, logic [31:0] base);
    for (int i = 0; i < n; i++) send(base + 32'(i), i == n - 1);
  endtask

  task automatic ctrl(logic [1:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    tick();
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0;
  endtask

  task automatic read_chk(string tag, int idx, logic [31:0] exp);
    rd_addr_i = AW'(idx * 4);
    tick();
    check32(tag, rd_data_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    running = 1'b1;
    tick();
    check32("R1 reset status", status_o, 32'h0000_0004);
    check32("R1 reset irq", {31'b0, irq_o}, 32'd0);

    // R10: word while idle is not stored
    send(32'hdead_0001, 1'b1);
    check32("R10 idle ignores word", status_o, 32'h0000_0004);

    // R2/R5/R8/R9: three-word message
    ctrl(2'b10);
    check32("R2 armed not idle", status_o, 32'h0000_0000);
    send_msg(3, 32'hA000_0000);
    check32("R5 done count 3", status_o, 32'h0003_0001);
    check32("R9 irq on done", {31'b0, irq_o}, 32'd1);
    for (int i = 0; i < 3; i++) read_chk("R8 read word", i, 32'hA000_0000 + 32'(i));

    // R7 and R2: done holds through words and a second arm write
    send_msg(2, 32'hB000_0000);
    ctrl(2'b10);
    check32("R7 done unchanged", status_o, 32'h0003_0001);
    read_chk("R7 word0 unchanged", 0, 32'hA000_0000);

    // R3 clear, R4 arm in mid-message
    ctrl(2'b01);
    check32("R3 clear to idle", status_o, 32'h0000_0004);
    check32("R3 irq low", {31'b0, irq_o}, 32'd0);
    send(32'hC000_0000, 1'b0);
    ctrl(2'b10);
    send(32'hC000_0001, 1'b0);
    send(32'hC000_0002, 1'b1);
    check32("R4 tail skipped", status_o, 32'h0000_0000);
    send(32'hD000_0000, 1'b0);
    tick();
    tick();
    send(32'hD000_0001, 1'b1);
    check32("R4 new message captured", status_o, 32'h0002_0001);
    read_chk("R4 first word", 0, 32'hD000_0000);
    read_chk("R4 second word", 1, 32'hD000_0001);

    // R6 overflow
    ctrl(2'b01);
    ctrl(2'b10);
    send_msg(20, 32'hE000_0000);
    check32("R6 error and saturated count", status_o, 32'h0010_0002);
    check32("R9 irq on error", {31'b0, irq_o}, 32'd1);
    read_chk("R6 word 0 kept", 0, 32'hE000_0000);
    read_chk("R6 word 15 kept", 15, 32'hE000_000F);
    send_msg(1, 32'hF000_0000);
    check32("R7 error unchanged", status_o, 32'h0010_0002);

    // R3 clear wins over arm in the same write
    ctrl(2'b11);
    check32("R3 clear beats arm", status_o, 32'h0000_0004);

    // exactly DEPTH words is done, not error
    ctrl(2'b10);
    send_msg(DEPTH, 32'h1000_0000);
    check32("R5 full-depth done", status_o, 32'h0010_0001);
    read_chk("R8 last slot", DEPTH - 1, 32'h1000_0000 + 32'(DEPTH - 1));

    // single-word message
    ctrl(2'b01);
    ctrl(2'b10);
    send_msg(1, 32'h2222_2222);
    check32("R5 single word", status_o, 32'h0001_0001);
    read_chk("R8 single word read", 0, 32'h2222_2222);

    tick();
    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule